// File: doc/BRIEF.md
# Flag-Based Integer Execute Unit

This unit executes the register-to-register class of a small 32-bit processor. That class covers add, subtract, multiply, bitwise and/or, unsigned divide and remainder, a compare, and a family of set-on-condition operations. A 64-bit instruction word arrives with a valid strobe. The unit names the two source registers it needs on a pair of combinational read ports of an external register file, and it returns its result as a registered write request. Compare is the only operation that touches the two status flags, zero and negative. The set-on-condition operations then turn a combination of those flags into a 0 or 1 in a register. No single operation both compares and sets a register.

Most operations complete in one cycle. Divide and remainder share a bit-serial restoring divider that takes 32 cycles. During that time `busy` is high and new strobes are ignored. A divisor of zero raises a trap pulse and writes nothing. An opcode outside the class raises an illegal pulse, and so does a register index beyond the configured depth. Register 0 always reads as zero and can never be written. A write that is being presented on the write port is forwarded to a source read in the same cycle, so dependent instructions can issue back to back.

Top module: `int_exec_unit`

## Requirements
- R1: Instruction fields: opcode in bits 63:58, destination index in 57:45, first source in 44:32, second source in 31:19. Opcode codes: ADD 0, SUB 1, MUL 2, DIV 3, MOD 4, AND 5, OR 6, CMP 7, EQ 8, NE 9, LT 10, LE 11, GE 12, GT 13. CMP reads the destination field and the first source field as its two operands.
- R2: An instruction is accepted on a rising edge where `in_valid` is high and `busy` is low. For ADD, SUB, MUL, AND and OR, the cycle after acceptance shows `done` and a write of the 32-bit wrapped result of source1 op source2 to the destination.
- R3: A source index of 0 supplies the value zero, whatever the register file returns for that index.
- R4: A destination index of 0 produces no write (`wr_en` stays low), but the completion pulse on `done` is still given.
- R5: CMP writes no register. In the cycle after acceptance, `flag_z` shows whether the operands are equal and `flag_n` shows whether the first is below the second as unsigned values. No other instruction changes the flags.
- R6: EQ, NE, LT, LE, GE and GT write Z, not Z, N, Z or N, not N, and (not Z and not N) respectively, as 0 or 1. They use the flags as they stood before the instruction.
- R7: DIV and MOD with a nonzero divisor write the unsigned quotient or remainder together with `done` 32 cycles after acceptance. `busy` is high in each cycle in between and low in the cycle of `done`.
- R8: A strobe presented while `busy` is high is ignored. It causes no write, no trap, no illegal pulse and no flag change.
- R9: DIV or MOD with a zero divisor gives `div_trap` together with `done` in the cycle after acceptance. It writes nothing and does not raise `busy`.
- R10: An opcode of 14 to 63 gives an `illegal` pulse in the cycle after acceptance. It gives no `done`, no write and no flag change.
- R11: An index at or above DEPTH in a field the opcode uses raises `illegal` as in R10. Arithmetic uses all three fields, CMP uses the destination and first source fields, and the set operations use the destination field only. Unused fields are not checked.
- R12: If a source index equals the index being written on the write port in the same cycle, the write data is used in place of the register file data.
- R13: While reset is asserted, `busy`, `done`, `wr_en`, `div_trap`, `illegal`, `flag_z` and `flag_n` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction strobe |
| in_word | input | 64 | Instruction word |
| rd_a_idx | output | 13 | Index on the first register-file read port |
| rd_a_data | input | 32 | Data from the first read port |
| rd_b_idx | output | 13 | Index on the second register-file read port |
| rd_b_data | input | 32 | Data from the second read port |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 13 | Register write index |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Divider occupied; strobes ignored |
| done | output | 1 | One-cycle completion pulse |
| div_trap | output | 1 | Divide-by-zero trap pulse |
| illegal | output | 1 | Illegal-instruction pulse |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative (unsigned below) flag |

## Verification
Single-cycle results, flag updates, trap pulses and illegal pulses belong to the cycle right after the accepting edge. A divide result belongs 32 cycles after that edge, and `busy` is high in the cycles between. A behavioural model in the bench advances on each rising edge, decides from the strobe and its own register copy what every output must show after that edge, and the outputs are compared with it at the following falling edge. Strobes held during a division, back-to-back dependent issues and a strobe held across the end of a division test that the cycle in which the result appears is the cycle the model predicts.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int IW   = 64;
  localparam int OPW  = 6;
  localparam int IDXW = 13;

  localparam int OP_LSB  = 58;
  localparam int DST_LSB = 45;
  localparam int S1_LSB  = 32;
  localparam int S2_LSB  = 19;

  localparam logic [OPW-1:0] OP_ADD = 6'd0;
  localparam logic [OPW-1:0] OP_SUB = 6'd1;
  localparam logic [OPW-1:0] OP_MUL = 6'd2;
  localparam logic [OPW-1:0] OP_DIV = 6'd3;
  localparam logic [OPW-1:0] OP_MOD = 6'd4;
  localparam logic [OPW-1:0] OP_AND = 6'd5;
  localparam logic [OPW-1:0] OP_OR  = 6'd6;
  localparam logic [OPW-1:0] OP_CMP = 6'd7;
  localparam logic [OPW-1:0] OP_SEQ = 6'd8;
  localparam logic [OPW-1:0] OP_SNE = 6'd9;
  localparam logic [OPW-1:0] OP_SLT = 6'd10;
  localparam logic [OPW-1:0] OP_SLE = 6'd11;
  localparam logic [OPW-1:0] OP_SGE = 6'd12;
  localparam logic [OPW-1:0] OP_SGT = 6'd13;

  typedef struct packed {
    logic known;
    logic arith;
    logic divide;
    logic is_mod;
    logic cmp;
    logic setop;
    logic use_s1;
    logic use_s2;
  } exu_dec_t;

endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic [IW-1:0]   word,
  output logic [OPW-1:0]  op,
  output logic [IDXW-1:0] dst,
  output logic [IDXW-1:0] ra_idx,
  output logic [IDXW-1:0] rb_idx,
  output exu_dec_t        dec,
  output logic            legal
);

  localparam logic [IDXW:0] DEPTH_L = (IDXW+1)'(DEPTH);

  logic [IDXW-1:0] s1;
  logic [IDXW-1:0] s2;
  logic            unused_low;

  assign op  = word[OP_LSB  +: OPW];
  assign dst = word[DST_LSB +: IDXW];
  assign s1  = word[S1_LSB  +: IDXW];
  assign s2  = word[S2_LSB  +: IDXW];
  assign unused_low = ^word[S2_LSB-1:0];

  always_comb begin
    dec = '0;
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR: begin
        dec.known  = 1'b1;
        dec.arith  = 1'b1;
        dec.use_s1 = 1'b1;
        dec.use_s2 = 1'b1;
      end
      OP_DIV, OP_MOD: begin
        dec.known  = 1'b1;
        dec.divide = 1'b1;
        dec.is_mod = (op == OP_MOD);
        dec.use_s1 = 1'b1;
        dec.use_s2 = 1'b1;
      end
      OP_CMP: begin
        dec.known  = 1'b1;
        dec.cmp    = 1'b1;
        dec.use_s1 = 1'b1;
      end
      OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_SGE, OP_SGT: begin
        dec.known = 1'b1;
        dec.setop = 1'b1;
      end
      default: dec = '0;
    endcase
  end

  // compare reads destination and first source fields; others read both sources
  assign ra_idx = dec.cmp ? dst : s1;
  assign rb_idx = dec.cmp ? s1  : s2;

  assign legal = dec.known
              && ({1'b0, dst} < DEPTH_L)
              && (!dec.use_s1 || ({1'b0, s1} < DEPTH_L))
              && (!dec.use_s2 || ({1'b0, s2} < DEPTH_L));

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            z_in,
  input  logic            n_in,
  output logic [XLEN-1:0] result,
  output logic            cmp_z,
  output logic            cmp_n
);

  logic cond;

  always_comb begin
    case (op)
      OP_SEQ:  cond = z_in;
      OP_SNE:  cond = !z_in;
      OP_SLT:  cond = n_in;
      OP_SLE:  cond = z_in || n_in;
      OP_SGE:  cond = !n_in;
      OP_SGT:  cond = !z_in && !n_in;
      default: cond = 1'b0;
    endcase
  end

  always_comb begin
    result = '0;
    case (op)
      OP_ADD:  result = opa + opb;
      OP_SUB:  result = opa - opb;
      OP_MUL:  result = opa * opb;
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_SGE, OP_SGT: result[0] = cond;
      default: result = '0;
    endcase
  end

  assign cmp_z = (opa == opb);
  assign cmp_n = (opa < opb);

endmodule

// File: rtl/exu_divider.sv
module exu_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int           CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n;
  logic          fin_q, fin_n;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    fin_n  = 1'b0;
    if (start) begin
      rem_n  = '0;
      quo_n  = dividend;
      dvs_n  = divisor;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (!diff[W]) begin
        rem_n = diff[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = shifted[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        fin_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      fin_q  <= fin_n;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IW-1:0]   in_word,
  output logic [IDXW-1:0] rd_a_idx,
  input  logic [XLEN-1:0] rd_a_data,
  output logic [IDXW-1:0] rd_b_idx,
  input  logic [XLEN-1:0] rd_b_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            busy,
  output logic            done,
  output logic            div_trap,
  output logic            illegal,
  output logic            flag_z,
  output logic            flag_n
);

  logic            rst_n_s;
  logic [OPW-1:0]  op;
  logic [IDXW-1:0] dst;
  exu_dec_t        dec;
  logic            legal;
  logic [XLEN-1:0] opa, opb;
  logic [XLEN-1:0] alu_res;
  logic            cmp_z, cmp_n;
  logic            accept;

  logic            dv_start, dv_busy, dv_fin;
  logic [XLEN-1:0] dv_quo, dv_rem;

  logic            sc_wr_q, sc_wr_n;
  logic            sc_done_q, sc_done_n;
  logic [IDXW-1:0] sc_idx_q, sc_idx_n;
  logic [XLEN-1:0] sc_data_q, sc_data_n;
  logic            trap_q, trap_n;
  logic            ill_q, ill_n;
  logic            z_q, z_n;
  logic            n_q, n_n;
  logic [IDXW-1:0] dv_idx_q, dv_idx_n;
  logic            dv_mod_q, dv_mod_n;

  exu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  exu_decode #(.DEPTH(DEPTH)) u_dec (
    .word   (in_word),
    .op     (op),
    .dst    (dst),
    .ra_idx (rd_a_idx),
    .rb_idx (rd_b_idx),
    .dec    (dec),
    .legal  (legal)
  );

  // operand select: register 0 is zero, pending write is forwarded
  always_comb begin
    if (rd_a_idx == '0)
      opa = '0;
    else if (wr_en && (wr_idx == rd_a_idx))
      opa = wr_data;
    else
      opa = rd_a_data;
    if (rd_b_idx == '0)
      opb = '0;
    else if (wr_en && (wr_idx == rd_b_idx))
      opb = wr_data;
    else
      opb = rd_b_data;
  end

  exu_alu #(.XLEN(XLEN)) u_alu (
    .op     (op),
    .opa    (opa),
    .opb    (opb),
    .z_in   (z_q),
    .n_in   (n_q),
    .result (alu_res),
    .cmp_z  (cmp_z),
    .cmp_n  (cmp_n)
  );

  exu_divider #(.W(XLEN)) u_div (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (dv_start),
    .dividend (opa),
    .divisor  (opb),
    .busy     (dv_busy),
    .fin      (dv_fin),
    .quo      (dv_quo),
    .rem      (dv_rem)
  );

  assign accept = in_valid && !dv_busy;

  always_comb begin
    sc_wr_n   = 1'b0;
    sc_done_n = 1'b0;
    trap_n    = 1'b0;
    ill_n     = 1'b0;
    sc_idx_n  = sc_idx_q;
    sc_data_n = sc_data_q;
    z_n       = z_q;
    n_n       = n_q;
    dv_start  = 1'b0;
    dv_idx_n  = dv_idx_q;
    dv_mod_n  = dv_mod_q;
    if (accept) begin
      if (!legal) begin
        ill_n = 1'b1;
      end else if (dec.divide) begin
        if (opb == '0) begin
          trap_n    = 1'b1;
          sc_done_n = 1'b1;
        end else begin
          dv_start = 1'b1;
          dv_idx_n = dst;
          dv_mod_n = dec.is_mod;
        end
      end else if (dec.cmp) begin
        z_n       = cmp_z;
        n_n       = cmp_n;
        sc_done_n = 1'b1;
      end else begin
        sc_done_n = 1'b1;
        sc_wr_n   = (dst != '0);
        sc_idx_n  = dst;
        sc_data_n = alu_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sc_wr_q   <= 1'b0;
      sc_done_q <= 1'b0;
      sc_idx_q  <= '0;
      sc_data_q <= '0;
      trap_q    <= 1'b0;
      ill_q     <= 1'b0;
      z_q       <= 1'b0;
      n_q       <= 1'b0;
      dv_idx_q  <= '0;
      dv_mod_q  <= 1'b0;
    end else begin
      sc_wr_q   <= sc_wr_n;
      sc_done_q <= sc_done_n;
      sc_idx_q  <= sc_idx_n;
      sc_data_q <= sc_data_n;
      trap_q    <= trap_n;
      ill_q     <= ill_n;
      z_q       <= z_n;
      n_q       <= n_n;
      dv_idx_q  <= dv_idx_n;
      dv_mod_q  <= dv_mod_n;
    end
  end

  assign wr_en    = sc_wr_q || (dv_fin && (dv_idx_q != '0));
  assign wr_idx   = dv_fin ? dv_idx_q : sc_idx_q;
  assign wr_data  = dv_fin ? (dv_mod_q ? dv_rem : dv_quo) : sc_data_q;
  assign done     = sc_done_q || dv_fin;
  assign busy     = dv_busy;
  assign div_trap = trap_q;
  assign illegal  = ill_q;
  assign flag_z   = z_q;
  assign flag_n   = n_q;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int XLEN = 32,
  parameter int IDXW = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            busy,
  input logic            done,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic            div_trap,
  input logic            illegal,
  input logic            flag_z,
  input logic            flag_n
);

  localparam int CW = $clog2(XLEN) + 1;

  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bcnt <= '0;
    else if (busy)
      bcnt <= bcnt + 1'b1;
    else
      bcnt <= '0;
  end

  assert_no_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != '0));

  assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_trap |-> (done && !wr_en && !busy));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !wr_en && !div_trap));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({flag_z, flag_n}));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!illegal && !div_trap));

  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_div_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (bcnt != '0)) |-> (bcnt == CW'(XLEN)));

endmodule

bind int_exec_unit exu_checker #(.XLEN(XLEN), .IDXW(exu_pkg::IDXW)) u_exu_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .busy     (busy),
  .done     (done),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .div_trap (div_trap),
  .illegal  (illegal),
  .flag_z   (flag_z),
  .flag_n   (flag_n)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  import exu_pkg::*;

  localparam int XLEN  = 32;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [63:0]     in_word;
  logic [12:0]     rd_a_idx, rd_b_idx;
  logic [31:0]     rd_a_data, rd_b_data;
  logic            wr_en;
  logic [12:0]     wr_idx;
  logic [31:0]     wr_data;
  logic            busy, done, div_trap, illegal, flag_z, flag_n;

  logic [31:0] mem  [DEPTH];
  logic [31:0] refm [DEPTH];

  int    nchk;
  int    nfail;
  bit    finished;
  string scen;

  // expected outputs after each rising edge
  logic        e_busy, e_done, e_wr, e_trap, e_ill, e_z, e_n;
  logic [12:0] e_idx;
  logic [31:0] e_data;
  int          dleft;
  logic [12:0] d_idx;
  logic [31:0] d_res;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int_exec_unit #(.XLEN(XLEN), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .done(done), .div_trap(div_trap), .illegal(illegal),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  function automatic logic [31:0] initval(int i);
    case (i)
      0:  return 32'hDEADBEEF;
      1:  return 32'h80000000;
      2:  return 32'h00000001;
      3:  return 32'h12345678;
      4:  return 32'h9ABCDEF1;
      11: return 32'hFFFFFFFF;
      12: return 32'h00000007;
      15: return 32'h00001000;
      16: return 32'h00000040;
      default: return 32'(i) * 32'h01000193;
    endcase
  endfunction

  function automatic logic [31:0] rdmem(logic [12:0] i);
    if (i < 13'(DEPTH)) return mem[i[AW-1:0]];
    return 32'h0;
  endfunction

  assign rd_a_data = rdmem(rd_a_idx);
  assign rd_b_data = rdmem(rd_b_idx);

  // external register file
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initval(i);
    end else if (wr_en && (wr_idx < 13'(DEPTH))) begin
      mem[wr_idx[AW-1:0]] <= wr_data;
    end
  end

  function automatic logic [63:0] mk(logic [5:0] op, int a, int b, int c);
    return {op, 13'(a), 13'(b), 13'(c), 19'd0};
  endfunction

  function automatic logic [31:0] rv(int i);
    if (i == 0) return 32'h0;
    return refm[i];
  endfunction

  task automatic model_exec(logic [63:0] w);
    int op, a, b, c;
    bit ok;
    logic [31:0] x, y, r;
    logic c_lt;
    op = int'(w[63:58]);
    a  = int'(w[57:45]);
    b  = int'(w[44:32]);
    c  = int'(w[31:19]);
    ok = (op <= 13) && (a < DEPTH) && ((op > 7) || (b < DEPTH)) && ((op > 6) || (c < DEPTH));
    if (!ok) begin
      e_ill = 1'b1;
      return;
    end
    if (op == 7) begin
      x = rv(a); y = rv(b);
      c_lt = (x < y);
      e_z = (x == y);
      e_n = c_lt;
      e_done = 1'b1;
      return;
    end
    x = (op <= 6) ? rv(b) : 32'h0;
    y = (op <= 6) ? rv(c) : 32'h0;
    if (op == 3 || op == 4) begin
      if (y == 32'h0) begin
        e_trap = 1'b1;
        e_done = 1'b1;
      end else begin
        d_res = (op == 3) ? (x / y) : (x % y);
        d_idx = 13'(a);
        dleft = 32;
        e_busy = 1'b1;
      end
      return;
    end
    case (op)
      0: r = x + y;
      1: r = x - y;
      2: r = x * y;
      5: r = x & y;
      6: r = x | y;
      8: r = {31'd0, e_z};
      9: r = {31'd0, !e_z};
      10: r = {31'd0, e_n};
      11: r = {31'd0, e_z || e_n};
      12: r = {31'd0, !e_n};
      default: r = {31'd0, !e_z && !e_n};
    endcase
    e_done = 1'b1;
    if (a != 0) begin
      e_wr = 1'b1; e_idx = 13'(a); e_data = r;
      refm[a] = r;
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) refm[i] = initval(i);
      e_busy = 0; e_done = 0; e_wr = 0; e_trap = 0; e_ill = 0;
      e_z = 0; e_n = 0; e_idx = 0; e_data = 0; dleft = 0; d_idx = 0; d_res = 0;
    end else begin
      e_done = 0; e_wr = 0; e_trap = 0; e_ill = 0;
      if (dleft > 0) begin
        dleft--;
        if (dleft == 0) begin
          e_busy = 1'b0;
          e_done = 1'b1;
          if (d_idx != 13'd0) begin
            e_wr = 1'b1; e_idx = d_idx; e_data = d_res;
            refm[int'(d_idx)] = d_res;
          end
        end
      end else if (in_valid) begin
        model_exec(in_word);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s (scenario %s) at %0t: actual %h expected %h", tag, scen, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 busy",      32'(busy),     32'(e_busy));
      chk("R2 done",      32'(done),     32'(e_done));
      chk("R4 wr_en",     32'(wr_en),    32'(e_wr));
      if (e_wr) begin
        chk("R2 wr_idx",  32'(wr_idx),   32'(e_idx));
        chk("R2 wr_data", wr_data,       e_data);
      end
      chk("R9 div_trap",  32'(div_trap), 32'(e_trap));
      chk("R10 illegal",  32'(illegal),  32'(e_ill));
      chk("R5 flag_z",    32'(flag_z),   32'(e_z));
      chk("R6 flag_n",    32'(flag_n),   32'(e_n));
    end
  end

  task automatic issue(logic [63:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog (scenario %s): actual hung expected completion", scen);
      summary();
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; finished = 1'b0; scen = "R13";
    rst_n = 1'b0; in_valid = 1'b0; in_word = 64'h0;
    repeat (3) @(negedge clk);
    chk("R13 busy",     32'(busy),     32'h0);
    chk("R13 done",     32'(done),     32'h0);
    chk("R13 wr_en",    32'(wr_en),    32'h0);
    chk("R13 div_trap", 32'(div_trap), 32'h0);
    chk("R13 illegal",  32'(illegal),  32'h0);
    chk("R13 flags",    32'({flag_z, flag_n}), 32'h0);
    rst_n = 1'b1;
    idle(4);

    scen = "R1 R2";
    issue(mk(OP_ADD, 5, 1, 2));
    issue(mk(OP_SUB, 6, 2, 1));
    issue(mk(OP_MUL, 7, 3, 4));
    issue(mk(OP_AND, 8, 3, 4));
    issue(mk(OP_OR,  9, 3, 4));
    idle(2);

    scen = "R12";
    issue(mk(OP_ADD, 10, 3, 4));
    issue(mk(OP_ADD, 18, 10, 10));
    issue(mk(OP_SUB, 19, 18, 10));
    idle(2);

    scen = "R3";
    issue(mk(OP_ADD, 20, 0, 3));
    issue(mk(OP_OR,  21, 4, 0));
    idle(1);

    scen = "R4";
    issue(mk(OP_ADD, 0, 3, 4));
    issue(mk(OP_ADD, 22, 0, 0));
    idle(1);

    scen = "R5 R6";
    issue(mk(OP_CMP, 1, 2, 0));
    for (int k = 8; k <= 13; k++) issue(mk(6'(k), 23 + k - 8, 0, 0));
    issue(mk(OP_CMP, 2, 1, 0));
    for (int k = 8; k <= 13; k++) issue(mk(6'(k), 23 + k - 8, 0, 0));
    issue(mk(OP_CMP, 3, 3, 0));
    for (int k = 8; k <= 13; k++) issue(mk(6'(k), 23 + k - 8, 0, 0));
    issue(mk(OP_CMP, 0, 0, 0));
    issue(mk(OP_SGE, 29, 0, 0));
    idle(2);

    scen = "R7 R8";
    issue(mk(OP_DIV, 23, 11, 12));
    issue(mk(OP_ADD, 24, 3, 4));
    issue(mk(6'd40, 24, 3, 4));
    issue(mk(OP_CMP, 3, 4, 0));
    idle(36);
    issue(mk(OP_MOD, 25, 11, 12));
    idle(34);
    issue(mk(OP_DIV, 26, 12, 11));
    idle(34);
    issue(mk(OP_MOD, 27, 12, 11));
    idle(34);
    issue(mk(OP_DIV, 0, 15, 16));
    idle(34);
    scen = "R7 R12";
    issue(mk(OP_DIV, 28, 15, 16));
    in_word = mk(OP_ADD, 29, 28, 28);
    repeat (33) @(negedge clk);
    issue(mk(OP_ADD, 24, 24, 0));
    idle(2);

    scen = "R9";
    issue(mk(OP_DIV, 30, 3, 0));
    issue(mk(OP_SUB, 14, 3, 3));
    issue(mk(OP_MOD, 30, 3, 14));
    issue(mk(OP_ADD, 31, 30, 0));
    idle(2);

    scen = "R10";
    issue(mk(OP_CMP, 2, 1, 0));
    issue(mk(6'd14, 5, 1, 2));
    issue(mk(6'd63, 0, 0, 0));
    issue(mk(OP_ADD, 5, 5, 0));
    idle(2);

    scen = "R11";
    issue(mk(OP_ADD, 5, 1, 40));
    issue(mk(OP_SEQ, 32, 0, 0));
    issue(mk(OP_CMP, 1, 33, 0));
    issue(mk(OP_SEQ, 5, 40, 50));
    issue(mk(OP_MUL, 8191, 1, 2));
    issue(mk(OP_CMP, 4, 3, 8000));
    idle(3);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule